// File: doc/BRIEF.md
# Debug Operation Sequencer for an 8051-Class Target

This block sits between a host-side controller and a two-wire debug link master. The host asks for one high-level operation at a time: read or write external data memory, read banked code memory, read or write internal RAM, halt, resume, single step, read status, read or write the configuration byte, chip erase, read the chip identifier, or read or write the program counter. The block expands each operation into a fixed, ordered list of link requests and hands them out one after another. For each request it gives a command byte, up to three argument bytes, and the number of reply bytes to expect.

Memory is reached by injecting real target instructions through the debug-instruction command. The low two bits of that command carry the instruction length. A data read first loads the data pointer and then executes a move from external memory. A code read first selects the bank in the memory control register and then uses the code-move instruction. The reply to the last request of an operation becomes the operation's result. A one-cycle done pulse reports the result, which then stays on the result port until the next operation completes.

Top module: `dbgseq_top`

## Requirements
- R1: While reset is held (`rst_n` low), `op_ready` is 1 and `lnk_req`, `op_done` and `op_result` are 0.
- R2: Operation codes are: 0 data read, 1 data write, 2 code read, 3 RAM read, 4 RAM write, 5 halt, 6 resume, 7 step, 8 status, 9 chip ID, 10 PC read, 11 PC write, 12 config read, 13 config write, 14 chip erase. Code 15 issues no link request. It pulses `op_done` in the cycle after acceptance with a result of 0, and `op_ready` stays 1.
- R3: A debug-instruction request has command 0x54 plus the instruction length (1 to 3), the instruction bytes as arguments, and a one-byte reply. Unused argument bytes are 0.
- R4: A data write issues three requests: 0x90 with address bits 15:8 and 7:0; then 0x74 with the value; then 0xF0.
- R5: A data read issues 0x90 with the address high and low bytes, then 0xE0. The result is the reply to 0xE0.
- R6: A code read issues four requests in this order. First, 0x75, 0xC7 and the byte bank*16+1, where bank is address bit 15 and up. Second, 0x90 with address bits 15:8 and 7:0. Third, 0xE4. Fourth, 0x93, whose reply is the result.
- R7: A RAM read issues 0xE4, then 0xE5 with address bits 7:0. A RAM write issues one request: 0x75, address bits 7:0, value.
- R8: Halt 0x44, resume 0x4C, step 0x5C, status 0x3F, config read 0x24 and erase 0x14 are each a single request with no arguments and a one-byte reply. The result is that byte, zero-extended.
- R9: PC write sends 0x02 with address bits 15:8 and then 7:0, with no reply. Config write sends 0x1D with the value, with no reply. Both give a result of 0.
- R10: Chip ID (0x68) and PC read (0x28) expect two reply bytes. The first byte received forms result bits 15:8.
- R11: Only one operation runs at a time. `op_valid` is ignored while `op_ready` is 0. Each request is held unchanged until `lnk_done`. `op_done` follows only the `lnk_done` of the last request.
- R12: `op_result` changes only with `op_done`. An operation offered during a done cycle is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle; offered operation is taken at this edge |
| op_code | input | 4 | Operation selector |
| op_addr | input | ADDR_W | Memory, RAM or PC address |
| op_wdata | input | 8 | Write value or configuration byte |
| op_done | output | 1 | One-cycle completion pulse |
| op_result | output | 16 | Reply of the final request |
| lnk_req | output | 1 | Link request pending |
| lnk_cmd | output | 8 | Command byte |
| lnk_nargs | output | 2 | Number of argument bytes |
| lnk_arg0 | output | 8 | First argument byte |
| lnk_arg1 | output | 8 | Second argument byte |
| lnk_arg2 | output | 8 | Third argument byte |
| lnk_nrep | output | 2 | Reply bytes expected |
| lnk_rx_vld | input | 1 | Reply byte strobe |
| lnk_rx_byte | input | 8 | Reply byte |
| lnk_done | input | 1 | Current request finished |

## Verification
Two events can land on the same clock edge: the completion of one operation and the acceptance of the next. The bench provokes this by keeping `op_valid` high with the following operation throughout each run. The scoreboard then requires every request of the new operation to come after the previous done pulse, with the previous result intact. A second coincidence is also driven: on alternating requests, the link model raises the final reply byte and `lnk_done` in the same cycle. The assembled byte must still reach the result.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

   typedef enum logic [3:0] {
      OP_XRD    = 4'd0,
      OP_XWR    = 4'd1,
      OP_CRD    = 4'd2,
      OP_IRD    = 4'd3,
      OP_IWR    = 4'd4,
      OP_HALT   = 4'd5,
      OP_RESUME = 4'd6,
      OP_STEP   = 4'd7,
      OP_STATUS = 4'd8,
      OP_CHIPID = 4'd9,
      OP_PCRD   = 4'd10,
      OP_PCWR   = 4'd11,
      OP_CFGRD  = 4'd12,
      OP_CFGWR  = 4'd13,
      OP_ERASE  = 4'd14,
      OP_NONE   = 4'd15
   } dbg_op_e;

   localparam logic [7:0] DI_BASE    = 8'h54;
   localparam logic [7:0] C_HALT     = 8'h44;
   localparam logic [7:0] C_RESUME   = 8'h4C;
   localparam logic [7:0] C_STEP     = 8'h5C;
   localparam logic [7:0] C_STATUS   = 8'h3F;
   localparam logic [7:0] C_CFGRD    = 8'h24;
   localparam logic [7:0] C_CFGWR    = 8'h1D;
   localparam logic [7:0] C_ERASE    = 8'h14;
   localparam logic [7:0] C_CHIPID   = 8'h68;
   localparam logic [7:0] C_PCRD     = 8'h28;
   localparam logic [7:0] C_PCWR     = 8'h02;

   localparam logic [7:0] I_LDDPTR   = 8'h90;
   localparam logic [7:0] I_MOVAIMM  = 8'h74;
   localparam logic [7:0] I_MOVXST   = 8'hF0;
   localparam logic [7:0] I_MOVXLD   = 8'hE0;
   localparam logic [7:0] I_CLRA     = 8'hE4;
   localparam logic [7:0] I_MOVCA    = 8'h93;
   localparam logic [7:0] I_MOVDIMM  = 8'h75;
   localparam logic [7:0] I_MOVADIR  = 8'hE5;

   typedef struct packed {
      logic [7:0] cmd;
      logic [1:0] nargs;
      logic [7:0] a0;
      logic [7:0] a1;
      logic [7:0] a2;
      logic [1:0] nrep;
      logic       last;
   } link_req_t;

   function automatic link_req_t mk_di(input logic [1:0] len, input logic [7:0] b0,
                                       input logic [7:0] b1, input logic [7:0] b2,
                                       input logic last);
      link_req_t r;
      r.cmd   = DI_BASE + {6'd0, len};
      r.nargs = len;
      r.a0    = b0;
      r.a1    = b1;
      r.a2    = b2;
      r.nrep  = 2'd1;
      r.last  = last;
      return r;
   endfunction

   function automatic link_req_t mk_raw(input logic [7:0] cmd, input logic [1:0] nargs,
                                        input logic [7:0] b0, input logic [7:0] b1,
                                        input logic [1:0] nrep);
      link_req_t r;
      r.cmd   = cmd;
      r.nargs = nargs;
      r.a0    = b0;
      r.a1    = b1;
      r.a2    = 8'h00;
      r.nrep  = nrep;
      r.last  = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/dbgseq_plan.sv
module dbgseq_plan
   import dbgseq_pkg::*;
#(
   parameter logic [7:0] MEMCTL_SFR = 8'hC7
) (
   input  dbg_op_e    op,
   input  logic [1:0] step,
   input  logic [15:0] addr,
   input  logic [3:0] bank,
   input  logic [7:0] wdata,
   output link_req_t  req
);

   logic [7:0] hi;
   logic [7:0] lo;
   logic [7:0] memctl_val;

   assign hi         = addr[15:8];
   assign lo         = addr[7:0];
   assign memctl_val = {bank, 4'h1};

   always_comb begin
      req      = '0;
      req.last = 1'b1;
      unique case (op)
         OP_XRD: begin
            if (step == 2'd0) req = mk_di(2'd3, I_LDDPTR, hi, lo, 1'b0);
            else              req = mk_di(2'd1, I_MOVXLD, 8'h00, 8'h00, 1'b1);
         end
         OP_XWR: begin
            case (step)
               2'd0:    req = mk_di(2'd3, I_LDDPTR, hi, lo, 1'b0);
               2'd1:    req = mk_di(2'd2, I_MOVAIMM, wdata, 8'h00, 1'b0);
               default: req = mk_di(2'd1, I_MOVXST, 8'h00, 8'h00, 1'b1);
            endcase
         end
         OP_CRD: begin
            case (step)
               2'd0:    req = mk_di(2'd3, I_MOVDIMM, MEMCTL_SFR, memctl_val, 1'b0);
               2'd1:    req = mk_di(2'd3, I_LDDPTR, hi, lo, 1'b0);
               2'd2:    req = mk_di(2'd1, I_CLRA, 8'h00, 8'h00, 1'b0);
               default: req = mk_di(2'd1, I_MOVCA, 8'h00, 8'h00, 1'b1);
            endcase
         end
         OP_IRD: begin
            if (step == 2'd0) req = mk_di(2'd1, I_CLRA, 8'h00, 8'h00, 1'b0);
            else              req = mk_di(2'd2, I_MOVADIR, lo, 8'h00, 1'b1);
         end
         OP_IWR:    req = mk_di(2'd3, I_MOVDIMM, lo, wdata, 1'b1);
         OP_HALT:   req = mk_raw(C_HALT,   2'd0, 8'h00, 8'h00, 2'd1);
         OP_RESUME: req = mk_raw(C_RESUME, 2'd0, 8'h00, 8'h00, 2'd1);
         OP_STEP:   req = mk_raw(C_STEP,   2'd0, 8'h00, 8'h00, 2'd1);
         OP_STATUS: req = mk_raw(C_STATUS, 2'd0, 8'h00, 8'h00, 2'd1);
         OP_CFGRD:  req = mk_raw(C_CFGRD,  2'd0, 8'h00, 8'h00, 2'd1);
         OP_ERASE:  req = mk_raw(C_ERASE,  2'd0, 8'h00, 8'h00, 2'd1);
         OP_CHIPID: req = mk_raw(C_CHIPID, 2'd0, 8'h00, 8'h00, 2'd2);
         OP_PCRD:   req = mk_raw(C_PCRD,   2'd0, 8'h00, 8'h00, 2'd2);
         OP_PCWR:   req = mk_raw(C_PCWR,   2'd2, hi, lo, 2'd0);
         OP_CFGWR:  req = mk_raw(C_CFGWR,  2'd1, wdata, 8'h00, 2'd0);
         default: begin
            req      = '0;
            req.last = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/dbgseq_reply.sv
module dbgseq_reply #(
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rx_vld,
   input  logic [7:0]       rx_byte,
   output logic [RES_W-1:0] word_next
);

   logic [RES_W-1:0] acc;

   generate
      if (RES_W < 16) begin : g_bad_width
         $error("dbgseq_reply: RES_W must hold two reply bytes");
      end
   endgenerate

   // earlier byte moves up, so the first byte received ends in the high half
   assign word_next = rx_vld ? {acc[RES_W-9:0], rx_byte} : acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (clr)    acc <= '0;
      else if (rx_vld) acc <= word_next;
   end

   // R10: a byte taken without a clear lands in the low byte of the accumulator
   a_r10_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld && !clr) |=> (acc[7:0] == $past(rx_byte)));

   // R10: a clear empties the accumulator
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));

endmodule

// File: rtl/dbgseq_ctrl.sv
module dbgseq_ctrl
   import dbgseq_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int RES_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        op_wdata,
   input  logic              req_last,
   input  logic              lnk_done,
   input  logic [RES_W-1:0]  word_next,
   output dbg_op_e           op_q,
   output logic [1:0]        step_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [7:0]        data_q,
   output logic              busy,
   output logic              op_ready,
   output logic              op_done,
   output logic [RES_W-1:0]  op_result
);

   typedef enum logic {S_IDLE, S_RUN} st_e;
   st_e st;

   logic accept;

   assign op_ready = (st == S_IDLE);
   assign busy     = (st == S_RUN);
   assign accept   = op_valid && op_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         op_q      <= OP_NONE;
         step_q    <= 2'd0;
         addr_q    <= '0;
         data_q    <= 8'h00;
         op_done   <= 1'b0;
         op_result <= '0;
      end else begin
         op_done <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (op_valid) begin
                  op_q   <= dbg_op_e'(op_code);
                  addr_q <= op_addr;
                  data_q <= op_wdata;
                  step_q <= 2'd0;
                  if (op_code == OP_NONE) begin
                     op_done   <= 1'b1;
                     op_result <= '0;
                  end else begin
                     st <= S_RUN;
                  end
               end
            end
            S_RUN: begin
               if (lnk_done) begin
                  if (req_last) begin
                     st        <= S_IDLE;
                     op_done   <= 1'b1;
                     op_result <= word_next;
                  end else begin
                     step_q <= step_q + 2'd1;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R11: completion follows a link completion or an immediately retired code
   a_r11_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |-> ($past(lnk_done) || $past(accept)));

   // R12: the result port moves only together with the done pulse
   a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_done |-> $stable(op_result));

   // R2: the empty code retires at once and never occupies the link
   a_r2_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_code == 4'hF) |=> (op_done && op_ready && op_result == '0));

   // R11: an accepted real operation keeps the block busy next cycle
   a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_code != 4'hF) |=> (busy && !op_done));

endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
   import dbgseq_pkg::*;
#(
   parameter int         ADDR_W     = 17,
   parameter logic [7:0] MEMCTL_SFR = 8'hC7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [3:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        op_wdata,
   output logic              op_done,
   output logic [15:0]       op_result,
   output logic              lnk_req,
   output logic [7:0]        lnk_cmd,
   output logic [1:0]        lnk_nargs,
   output logic [7:0]        lnk_arg0,
   output logic [7:0]        lnk_arg1,
   output logic [7:0]        lnk_arg2,
   output logic [1:0]        lnk_nrep,
   input  logic              lnk_rx_vld,
   input  logic [7:0]        lnk_rx_byte,
   input  logic              lnk_done
);

   localparam int RES_W  = 16;
   localparam int BANK_W = ADDR_W - 15;

   generate
      if (ADDR_W < 16 || ADDR_W > 19) begin : g_bad_addr
         $error("dbgseq_top: ADDR_W must lie between 16 and 19");
      end
   endgenerate

   dbg_op_e           op_q;
   logic [1:0]        step_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic              busy;
   logic [3:0]        bank;
   logic [RES_W-1:0]  word_next;
   link_req_t         req;

   generate
      if (BANK_W >= 4) begin : g_bank_full
         assign bank = addr_q[18:15];
      end else begin : g_bank_pad
         assign bank = {{(4 - BANK_W){1'b0}}, addr_q[ADDR_W-1:15]};
      end
   endgenerate

   dbgseq_ctrl #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .op_addr   (op_addr),
      .op_wdata  (op_wdata),
      .req_last  (req.last),
      .lnk_done  (lnk_done),
      .word_next (word_next),
      .op_q      (op_q),
      .step_q    (step_q),
      .addr_q    (addr_q),
      .data_q    (data_q),
      .busy      (busy),
      .op_ready  (op_ready),
      .op_done   (op_done),
      .op_result (op_result)
   );

   dbgseq_plan #(.MEMCTL_SFR(MEMCTL_SFR)) u_plan (
      .op    (op_q),
      .step  (step_q),
      .addr  (addr_q[15:0]),
      .bank  (bank),
      .wdata (data_q),
      .req   (req)
   );

   dbgseq_reply #(.RES_W(RES_W)) u_reply (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (lnk_done),
      .rx_vld    (lnk_rx_vld),
      .rx_byte   (lnk_rx_byte),
      .word_next (word_next)
   );

   assign lnk_req   = busy;
   assign lnk_cmd   = busy ? req.cmd   : 8'h00;
   assign lnk_nargs = busy ? req.nargs : 2'd0;
   assign lnk_arg0  = busy ? req.a0    : 8'h00;
   assign lnk_arg1  = busy ? req.a1    : 8'h00;
   assign lnk_arg2  = busy ? req.a2    : 8'h00;
   assign lnk_nrep  = busy ? req.nrep  : 2'd0;

   // R3: debug-instruction commands carry their length in the low bits
   a_r3_di_length: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_req && lnk_cmd[7:2] == 6'b010101) |->
         (lnk_cmd[1:0] == lnk_nargs && lnk_cmd[1:0] != 2'd0 && lnk_nrep == 2'd1));

   // R11: a pending request is held unchanged until the link finishes it
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_req && !lnk_done) |=>
         (lnk_req && $stable(lnk_cmd) && $stable(lnk_arg0) && $stable(lnk_arg1)
          && $stable(lnk_arg2) && $stable(lnk_nrep)));

   // R11: the block is never idle and requesting at once
   a_r11_single_op: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_req |-> !op_ready);

endmodule

// File: tb/dbgseq_top_test.sv
module dbgseq_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [3:0]  op_code = 4'h0;
   logic [16:0] op_addr = '0;
   logic [7:0]  op_wdata = 8'h00;
   logic        op_done;
   logic [15:0] op_result;
   logic        lnk_req;
   logic [7:0]  lnk_cmd;
   logic [1:0]  lnk_nargs;
   logic [7:0]  lnk_arg0, lnk_arg1, lnk_arg2;
   logic [1:0]  lnk_nrep;
   logic        lnk_rx_vld = 1'b0;
   logic [7:0]  lnk_rx_byte = 8'h00;
   logic        lnk_done = 1'b0;

   int checks = 0;
   int errors = 0;
   int hold_err = 0;
   bit ended = 1'b0;

   logic [35:0] exp_req[$];
   string       exp_req_tag[$];
   logic [15:0] exp_res[$];
   string       exp_res_tag[$];
   logic [15:0] last_res;
   logic [15:0] held_res = 16'h0000;

   always #5 clk = ~clk;

   dbgseq_top #(.ADDR_W(17)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_code(op_code), .op_addr(op_addr), .op_wdata(op_wdata),
      .op_done(op_done), .op_result(op_result), .lnk_req(lnk_req),
      .lnk_cmd(lnk_cmd), .lnk_nargs(lnk_nargs), .lnk_arg0(lnk_arg0),
      .lnk_arg1(lnk_arg1), .lnk_arg2(lnk_arg2), .lnk_nrep(lnk_nrep),
      .lnk_rx_vld(lnk_rx_vld), .lnk_rx_byte(lnk_rx_byte), .lnk_done(lnk_done)
   );

   function automatic logic [7:0] rep_byte(input logic [7:0] cmd, input logic [7:0] a0, input int j);
      return cmd ^ a0 ^ ((j == 0) ? 8'h3C : 8'hA5);
   endfunction

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push_req(input string tag, input logic [7:0] cmd, input logic [1:0] n,
                           input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
                           input logic [1:0] nrep);
      exp_req.push_back({cmd, n, a0, a1, a2, nrep});
      exp_req_tag.push_back(tag);
      if (nrep == 2'd0)      last_res = 16'h0000;
      else if (nrep == 2'd1) last_res = {8'h00, rep_byte(cmd, a0, 0)};
      else                   last_res = {rep_byte(cmd, a0, 0), rep_byte(cmd, a0, 1)};
   endtask

   // debug-instruction request: 0x54 + length, one reply byte (R3)
   task automatic push_di(input string tag, input logic [1:0] len, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2);
      push_req(tag, 8'h54 + {6'd0, len}, len, b0, b1, b2, 2'd1);
   endtask

   task automatic run_op(input logic [3:0] c, input logic [16:0] a, input logic [7:0] w);
      string t;
      logic [7:0] hi, lo;
      hi = a[15:8];
      lo = a[7:0];
      last_res = 16'h0000;
      case (c)
         4'd0:  begin t = "R5 xdata read";  push_di(t, 2'd3, 8'h90, hi, lo); push_di(t, 2'd1, 8'hE0, 8'h00, 8'h00); end
         4'd1:  begin t = "R4 xdata write"; push_di(t, 2'd3, 8'h90, hi, lo); push_di(t, 2'd2, 8'h74, w, 8'h00);
                      push_di(t, 2'd1, 8'hF0, 8'h00, 8'h00); end
         4'd2:  begin t = "R6 code read";   push_di(t, 2'd3, 8'h75, 8'hC7, {2'b00, a[16:15], 4'h1});
                      push_di(t, 2'd3, 8'h90, hi, lo); push_di(t, 2'd1, 8'hE4, 8'h00, 8'h00);
                      push_di(t, 2'd1, 8'h93, 8'h00, 8'h00); end
         4'd3:  begin t = "R7 iram read";   push_di(t, 2'd1, 8'hE4, 8'h00, 8'h00); push_di(t, 2'd2, 8'hE5, lo, 8'h00); end
         4'd4:  begin t = "R7 iram write";  push_di(t, 2'd3, 8'h75, lo, w); end
         4'd5:  begin t = "R8 halt";        push_req(t, 8'h44, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1); end
         4'd6:  begin t = "R8 resume";      push_req(t, 8'h4C, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1); end
         4'd7:  begin t = "R8 step";        push_req(t, 8'h5C, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1); end
         4'd8:  begin t = "R8 status";      push_req(t, 8'h3F, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1); end
         4'd9:  begin t = "R10 chip id";    push_req(t, 8'h68, 2'd0, 8'h00, 8'h00, 8'h00, 2'd2); end
         4'd10: begin t = "R10 pc read";    push_req(t, 8'h28, 2'd0, 8'h00, 8'h00, 8'h00, 2'd2); end
         4'd11: begin t = "R9 pc write";    push_req(t, 8'h02, 2'd2, hi, lo, 8'h00, 2'd0); end
         4'd12: begin t = "R8 config read"; push_req(t, 8'h24, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1); end
         4'd13: begin t = "R9 config write"; push_req(t, 8'h1D, 2'd1, w, 8'h00, 8'h00, 2'd0); end
         4'd14: begin t = "R8 erase";       push_req(t, 8'h14, 2'd0, 8'h00, 8'h00, 8'h00, 2'd1); end
         default: t = "R2 empty code";
      endcase
      exp_res.push_back(last_res);
      exp_res_tag.push_back(t);
      // offer the operation and keep it offered until it is taken (R11, R12)
      op_valid = 1'b1;
      op_code  = c;
      op_addr  = a;
      op_wdata = w;
      while (!op_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // link model: checks each request against the scoreboard and answers it
   initial begin
      int lat_ctr = 0;
      forever begin
         @(negedge clk);
         if (rst_n && lnk_req) begin
            logic [35:0] got;
            logic [7:0]  c0, g0;
            int nrep, lat;
            bit merged;
            got = {lnk_cmd, lnk_nargs, lnk_arg0, lnk_arg1, lnk_arg2, lnk_nrep};
            c0 = lnk_cmd;
            g0 = lnk_arg0;
            nrep = int'(lnk_nrep);
            if (exp_req.size() == 0) begin
               chk("R11 unexpected link request", got, 36'h0);
            end else begin
               chk(exp_req_tag.pop_front(), got, exp_req.pop_front());
            end
            lat = lat_ctr % 3;
            merged = lat_ctr[0];
            lat_ctr++;
            repeat (lat) @(negedge clk);
            for (int j = 0; j < nrep; j++) begin
               lnk_rx_vld  = 1'b1;
               lnk_rx_byte = rep_byte(c0, g0, j);
               if (j == nrep - 1 && merged) lnk_done = 1'b1;
               @(negedge clk);
               lnk_rx_vld = 1'b0;
            end
            if (!(merged && nrep > 0)) begin
               lnk_done = 1'b1;
               @(negedge clk);
            end
            lnk_done = 1'b0;
         end
      end
   end

   // result monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (op_done) begin
               if (exp_res.size() == 0) begin
                  chk("R11 unexpected done", {20'h0, op_result}, 36'h0);
               end else begin
                  chk(exp_res_tag.pop_front(), {20'h0, op_result}, {20'h0, exp_res.pop_front()});
               end
               held_res = op_result;
            end else if (op_result !== held_res) begin
               hold_err++;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ready in reset", {35'h0, op_ready}, 36'h1);
      chk("R1 no request in reset", {35'h0, lnk_req}, 36'h0);
      chk("R1 no done in reset", {35'h0, op_done}, 36'h0);
      chk("R1 result zero in reset", {20'h0, op_result}, 36'h0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(4'd1, 17'h0F012, 8'h5A);
      run_op(4'd0, 17'h0ABCD, 8'h00);
      run_op(4'd2, 17'h12345, 8'h00);
      run_op(4'd2, 17'h08001, 8'h00);
      run_op(4'd2, 17'h00010, 8'h00);
      run_op(4'd3, 17'h00033, 8'h00);
      run_op(4'd4, 17'h00044, 8'h99);
      run_op(4'd5, 17'h00000, 8'h00);
      run_op(4'd6, 17'h00000, 8'h00);
      run_op(4'd7, 17'h00000, 8'h00);
      run_op(4'd8, 17'h00000, 8'h00);
      run_op(4'd12, 17'h00000, 8'h00);
      run_op(4'd14, 17'h00000, 8'h00);
      run_op(4'd9, 17'h00000, 8'h00);
      run_op(4'd10, 17'h00000, 8'h00);
      run_op(4'd11, 17'h1F0A0, 8'h00);
      run_op(4'd13, 17'h00000, 8'h01);
      run_op(4'd15, 17'h0FFFF, 8'hFF);
      run_op(4'd15, 17'h00000, 8'h00);
      run_op(4'd9, 17'h00000, 8'h00);
      run_op(4'd15, 17'h00000, 8'h00);
      run_op(4'd0, 17'h1FFFF, 8'h00);
      op_valid = 1'b0;

      for (int i = 0; i < 2000 && (exp_res.size() != 0 || exp_req.size() != 0); i++)
         @(negedge clk);
      repeat (10) @(negedge clk);
      chk("R11 all requests issued", 36'(exp_req.size()), 36'h0);
      chk("R11 all operations done", 36'(exp_res.size()), 36'h0);
      chk("R12 result held between done pulses", 36'(hold_err), 36'h0);
      chk("R2 idle after run", {35'h0, op_ready}, 36'h1);
      finish_run();
   end

endmodule